// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single characters over the one-wire, half-duplex I/O line of an ISO 7816 style card. It divides the system clock into the card clock, derives the elementary time unit (ETU) from a selectable number of card-clock periods, and sends or receives characters. Each character is a low start bit, eight data bits and an even parity bit, followed by at least two ETU of guard time at the high level. Both the direct and the inverse coding conventions are supported.

The host sets the line direction. In transmit direction it writes bytes into a one-entry holding register and gets a transmit request once a character has fully left with nothing queued behind it. In receive direction the incoming characters, each with a parity-ok flag, collect in a small FIFO. A character wait timer reports when the card has stopped talking. The four interrupt sources share one status vector, have one mask bit each, and drive a single interrupt output.

Top module: `sc_char_xcvr`

## Requirements
- R1: While `cfg_clk_run` is 1 the card clock has a period of 4 system clocks (`cfg_clk_div8`=0) or 8 system clocks (`cfg_clk_div8`=1), high for the first half of each period.
- R2: While `cfg_clk_run` is 0 the card clock rests at the level of `cfg_clk_idle_hi`.
- R3: One ETU lasts (4 or 8) x (ETU_DIV_A when `cfg_etu_long`=0, ETU_DIV_B when it is 1) system clocks. A transmitted character is 12 ETU on `io_out`: start bit 0, eight data bits, parity, then two guard ETU at 1. The line is 1 whenever the transmitter is idle.
- R4: With `cfg_inverse`=0 the data go least significant bit first at their true level and the parity bit is the XOR of the data bits. With `cfg_inverse`=1 the data go most significant bit first, and data and parity are both inverted on the line. The start bit is 0 in both conventions.
- R5: A received character is decoded with the same convention rules. `rx_par_ok` is 1 when the received parity matches the even parity of the data, and it is always 1 when `cfg_par_chk` is 0.
- R6: `io_oe` equals `cfg_dir_tx`. While `cfg_dir_tx` is 1, activity on `io_in` stores no character.
- R7: `irq_stat[1]` (transmit request) rises when a character finishes in transmit direction and no byte is waiting. A `tx_wr` or a switch of `cfg_dir_tx` from 1 to 0 clears it.
- R8: `irq_stat[0]` (receive ready) is 1 while the FIFO holds a character. `rx_data` and `rx_par_ok` show the oldest entry, and `rx_rd` removes it, so bytes leave in arrival order.
- R9: A character that arrives while the FIFO is full is dropped and sets `irq_stat[2]` (overflow).
- R10: `irq_stat[3]` (wait timeout) sets once `cfg_cwt` ETU have passed without a start bit, counted from the end of the last received character or from entry into receive direction. A `cfg_cwt` of 0 turns the timer off.
- R11: A `stat_rd` pulse clears `irq_stat[2]` and `irq_stat[3]`, unless the same event occurs in that cycle.
- R12: `irq` is 1 exactly when some `irq_stat` bit is 1 and its `irq_mask` bit is 0. A mask bit of 1 blocks its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clk_run | input | 1 | Card clock running |
| cfg_clk_div8 | input | 1 | Card clock divisor 8 (else 4) |
| cfg_clk_idle_hi | input | 1 | Card clock level while stopped |
| cfg_etu_long | input | 1 | Use the longer ETU divisor |
| cfg_inverse | input | 1 | Inverse coding convention |
| cfg_par_chk | input | 1 | Check received parity |
| cfg_dir_tx | input | 1 | Line direction: 1 transmit, 0 receive |
| cfg_cwt | input | CWT_W | Character wait time in ETU, 0 = off |
| irq_mask | input | 4 | Per-source mask, 1 = blocked |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_data | input | 8 | Byte to send |
| rx_rd | input | 1 | Pop the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_par_ok | output | 1 | Parity status of rx_data |
| stat_rd | input | 1 | Status read strobe (clears event bits) |
| irq_stat | output | 4 | {wait timeout, overflow, tx request, rx ready} |
| irq | output | 1 | Combined unmasked interrupt |
| card_clk | output | 1 | Card clock |
| io_in | input | 1 | Sampled I/O line |
| io_out | output | 1 | Driven I/O level |
| io_oe | output | 1 | I/O driver enable |

## Verification
The bench builds the block with ETU divisors of 5 and 7 card clocks in place of 372 and 512, a 4-entry FIFO and a 4-bit wait-time field. A 12-ETU character then takes at most 672 system clocks, so the bench sweeps every combination of clock divisor, ETU divisor and coding convention for both sending and receiving. An overflow needs only five back-to-back characters, and the wait-timer edge can be bracketed to within half an ETU.

// File: rtl/sc_xcvr_pkg.sv
package sc_xcvr_pkg;
    localparam int ST_RX_RDY = 0;
    localparam int ST_TX_REQ = 1;
    localparam int ST_RX_OV  = 2;
    localparam int ST_CWT    = 3;
    localparam int NUM_IRQ   = 4;
    localparam int FRAME_ETU = 12;

    typedef struct packed {
        logic [7:0] data;
        logic       par_ok;
    } rx_char_t;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_st_e;
endpackage

// File: rtl/sc_clk_gen.sv
module sc_clk_gen #(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic idle_hi,
    input  logic div_hi,
    output logic card_clk
);
    localparam int CW = $clog2(DIV_HI);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } st_t;

    st_t s_d, s_q;
    logic [CW-1:0] last, half;

    always_comb begin
        last = div_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
        half = div_hi ? CW'(DIV_HI / 2) : CW'(DIV_LO / 2);
        s_d  = s_q;
        if (!run) begin
            s_d.cnt = '0;
            s_d.lvl = idle_hi;
        end else begin
            s_d.cnt = (s_q.cnt >= last) ? '0 : s_q.cnt + 1'b1;
            s_d.lvl = (s_d.cnt < half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign card_clk = s_q.lvl;
endmodule

// File: rtl/sc_tx.sv
module sc_tx #(
    parameter int EW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] etu_last,
    input  logic          start,
    input  logic [7:0]    data,
    input  logic          inverse,
    output logic          line,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        logic          busy;
        logic [11:0]   sh;
        logic [3:0]    bitn;
        logic [EW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;
    logic [11:0] frame;
    logic        par;

    always_comb begin
        par      = ^data;
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++)
            frame[1+i] = inverse ? ~data[7-i] : data[i];
        frame[9] = inverse ? ~par : par;
    end

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.sh   = frame;
                s_d.bitn = '0;
                s_d.cnt  = '0;
            end
        end else if (s_q.cnt == etu_last) begin
            s_d.cnt = '0;
            if (s_q.bitn == 4'd11) begin
                s_d.busy = 1'b0;
                s_d.sh   = '1;
                done     = 1'b1;
            end else begin
                s_d.sh   = {1'b1, s_q.sh[11:1]};
                s_d.bitn = s_q.bitn + 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{busy: 1'b0, sh: '1, bitn: '0, cnt: '0};
        else        s_q <= s_d;
    end

    assign line = s_q.sh[0];
    assign busy = s_q.busy;
endmodule

// File: rtl/sc_rx.sv
module sc_rx
    import sc_xcvr_pkg::*;
#(
    parameter int EW    = 13,
    parameter int CWT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             line_in,
    input  logic [EW-1:0]    etu_last,
    input  logic             inverse,
    input  logic             par_chk,
    input  logic [CWT_W-1:0] cwt,
    output logic             push,
    output rx_char_t         char_o,
    output logic             wt_hit
);
    typedef struct packed {
        logic [1:0]       sync;
        logic             prev;
        logic             en_q;
        rx_st_e           st;
        logic [EW-1:0]    cnt;
        logic [3:0]       bitn;
        logic [8:0]       sh;
        logic             armed;
        logic [CWT_W-1:0] wcnt;
    } st_t;

    st_t s_d, s_q;
    logic       line, fall, tick, pbit;
    logic [8:0] sh_n;

    always_comb begin
        s_d      = s_q;
        push     = 1'b0;
        wt_hit   = 1'b0;
        s_d.sync = {s_q.sync[0], line_in};
        s_d.prev = s_q.sync[1];
        s_d.en_q = en;
        line     = s_q.sync[1];
        fall     = s_q.prev & ~s_q.sync[1];
        tick     = (s_q.cnt == etu_last);
        sh_n     = {line, s_q.sh[8:1]};
        if (!en) begin
            s_d.st    = RX_IDLE;
            s_d.armed = 1'b0;
            s_d.cnt   = '0;
            s_d.wcnt  = '0;
        end else if (!s_q.en_q) begin
            s_d.st    = RX_IDLE;
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
            s_d.wcnt  = '0;
        end else begin
            unique case (s_q.st)
                RX_START: begin
                    if (s_q.cnt == (etu_last >> 1)) begin
                        s_d.cnt  = '0;
                        s_d.bitn = '0;
                        s_d.st   = line ? RX_IDLE : RX_BITS;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (tick) begin
                        s_d.cnt  = '0;
                        s_d.sh   = sh_n;
                        s_d.bitn = s_q.bitn + 1'b1;
                        if (s_q.bitn == 4'd8) begin
                            push      = 1'b1;
                            s_d.st    = RX_HOLD;
                            s_d.armed = 1'b1;
                            s_d.wcnt  = '0;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (s_q.st == RX_IDLE && fall) begin
                        s_d.st  = RX_START;
                        s_d.cnt = '0;
                    end else begin
                        if (s_q.st == RX_HOLD && line) s_d.st = RX_IDLE;
                        s_d.cnt = tick ? '0 : s_q.cnt + 1'b1;
                        if (tick && s_q.armed && cwt != '0) begin
                            if (s_q.wcnt + 1'b1 == cwt) begin
                                wt_hit    = 1'b1;
                                s_d.armed = 1'b0;
                                s_d.wcnt  = '0;
                            end else begin
                                s_d.wcnt = s_q.wcnt + 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        for (int i = 0; i < 8; i++)
            char_o.data[i] = inverse ? ~sh_n[7-i] : sh_n[i];
        pbit          = inverse ? ~sh_n[8] : sh_n[8];
        char_o.par_ok = ~par_chk | ((^char_o.data) == pbit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sync: 2'b11, prev: 1'b1, en_q: 1'b0, st: RX_IDLE,
                             cnt: '0, bitn: '0, sh: '0, armed: 1'b0, wcnt: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sc_fifo.sv
module sc_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [AW:0]             cnt;
    } st_t;

    st_t  s_d, s_q;
    logic do_push, do_pop;

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == (AW+1)'(DEPTH));
    assign dout  = s_q.mem[s_q.rp];

    always_comb begin
        s_d     = s_q;
        do_push = push & ~full;
        do_pop  = pop & ~empty;
        if (do_push) begin
            s_d.mem[s_q.wp] = din;
            s_d.wp          = s_q.wp + 1'b1;
        end
        if (do_pop) s_d.rp = s_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
    import sc_xcvr_pkg::*;
#(
    parameter int CLK_DIV_LO = 4,
    parameter int CLK_DIV_HI = 8,
    parameter int ETU_DIV_A  = 372,
    parameter int ETU_DIV_B  = 512,
    parameter int FIFO_DEPTH = 8,
    parameter int CWT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_clk_run,
    input  logic             cfg_clk_div8,
    input  logic             cfg_clk_idle_hi,
    input  logic             cfg_etu_long,
    input  logic             cfg_inverse,
    input  logic             cfg_par_chk,
    input  logic             cfg_dir_tx,
    input  logic [CWT_W-1:0] cfg_cwt,
    input  logic [3:0]       irq_mask,
    input  logic             tx_wr,
    input  logic [7:0]       tx_data,
    input  logic             rx_rd,
    output logic [7:0]       rx_data,
    output logic             rx_par_ok,
    input  logic             stat_rd,
    output logic [3:0]       irq_stat,
    output logic             irq,
    output logic             card_clk,
    input  logic             io_in,
    output logic             io_out,
    output logic             io_oe
);
    localparam int EW     = $clog2(CLK_DIV_HI * ETU_DIV_B + 1);
    localparam int E_LO_A = CLK_DIV_LO * ETU_DIV_A - 1;
    localparam int E_LO_B = CLK_DIV_LO * ETU_DIV_B - 1;
    localparam int E_HI_A = CLK_DIV_HI * ETU_DIV_A - 1;
    localparam int E_HI_B = CLK_DIV_HI * ETU_DIV_B - 1;

    typedef struct packed {
        logic [7:0] hold;
        logic       hold_v;
        logic       tx_req;
        logic       ov;
        logic       wt;
        logic       dir_q;
    } st_t;

    st_t      s_d, s_q;
    logic [EW-1:0] etu_last;
    logic     tx_start, tx_busy, tx_done, tx_line;
    logic     rx_push, rx_wt, fifo_empty, fifo_full;
    rx_char_t rx_char, fifo_head;

    always_comb begin
        case ({cfg_clk_div8, cfg_etu_long})
            2'b00:   etu_last = EW'(E_LO_A);
            2'b01:   etu_last = EW'(E_LO_B);
            2'b10:   etu_last = EW'(E_HI_A);
            default: etu_last = EW'(E_HI_B);
        endcase
    end

    sc_clk_gen #(.DIV_LO(CLK_DIV_LO), .DIV_HI(CLK_DIV_HI)) clk_gen_i (
        .clk(clk), .rst_n(rst_n), .run(cfg_clk_run), .idle_hi(cfg_clk_idle_hi),
        .div_hi(cfg_clk_div8), .card_clk(card_clk));

    sc_tx #(.EW(EW)) tx_i (
        .clk(clk), .rst_n(rst_n), .etu_last(etu_last), .start(tx_start),
        .data(s_q.hold), .inverse(cfg_inverse), .line(tx_line),
        .busy(tx_busy), .done(tx_done));

    sc_rx #(.EW(EW), .CWT_W(CWT_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .en(~cfg_dir_tx), .line_in(io_in),
        .etu_last(etu_last), .inverse(cfg_inverse), .par_chk(cfg_par_chk),
        .cwt(cfg_cwt), .push(rx_push), .char_o(rx_char), .wt_hit(rx_wt));

    sc_fifo #(.W($bits(rx_char_t)), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_char), .pop(rx_rd),
        .dout(fifo_head), .empty(fifo_empty), .full(fifo_full));

    assign tx_start = cfg_dir_tx & s_q.hold_v & ~tx_busy;

    always_comb begin
        s_d       = s_q;
        s_d.dir_q = cfg_dir_tx;
        if (tx_start) s_d.hold_v = 1'b0;
        if (tx_wr) begin
            s_d.hold   = tx_data;
            s_d.hold_v = 1'b1;
        end
        if (tx_done && cfg_dir_tx && !s_d.hold_v) s_d.tx_req = 1'b1;
        if (tx_wr || (s_q.dir_q && !cfg_dir_tx))  s_d.tx_req = 1'b0;
        s_d.ov = (s_q.ov & ~stat_rd) | (rx_push & fifo_full);
        s_d.wt = (s_q.wt & ~stat_rd) | rx_wt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        irq_stat            = '0;
        irq_stat[ST_RX_RDY] = ~fifo_empty;
        irq_stat[ST_TX_REQ] = s_q.tx_req;
        irq_stat[ST_RX_OV]  = s_q.ov;
        irq_stat[ST_CWT]    = s_q.wt;
    end

    assign irq       = |(irq_stat & ~irq_mask);
    assign rx_data   = fifo_head.data;
    assign rx_par_ok = fifo_head.par_ok;
    assign io_out    = tx_line;
    assign io_oe     = cfg_dir_tx;
endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_dir_tx,
    input logic       cfg_clk_run,
    input logic       cfg_clk_idle_hi,
    input logic       stat_rd,
    input logic       tx_wr,
    input logic [3:0] irq_stat,
    input logic [3:0] irq_mask,
    input logic       irq,
    input logic       card_clk,
    input logic       io_out,
    input logic       rx_push,
    input logic       rx_wt,
    input logic       fifo_full,
    input logic       tx_busy
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !cfg_clk_run && $past(!cfg_clk_run) && $stable(cfg_clk_idle_hi)
        |-> card_clk == cfg_clk_idle_hi); // R2
    AST_TX_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> io_out); // R3
    AST_RX_QUIET_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dir_tx |-> !rx_push); // R6
    AST_TXREQ_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !irq_stat[1]); // R7
    AST_OV_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && fifo_full |=> irq_stat[2]); // R9
    AST_WT_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !rx_wt |=> !irq_stat[3]); // R11
    AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask == 4'hF |-> !irq); // R12
endmodule

bind sc_char_xcvr sc_char_xcvr_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_dir_tx(cfg_dir_tx), .cfg_clk_run(cfg_clk_run),
    .cfg_clk_idle_hi(cfg_clk_idle_hi), .stat_rd(stat_rd), .tx_wr(tx_wr),
    .irq_stat(irq_stat), .irq_mask(irq_mask), .irq(irq), .card_clk(card_clk),
    .io_out(io_out), .rx_push(rx_push), .rx_wt(rx_wt), .fifo_full(fifo_full),
    .tx_busy(tx_busy));

// File: tb/sc_char_xcvr_tb_top.sv
`timescale 1ns/1ps
module sc_char_xcvr_tb_top;
    localparam int EA = 5;
    localparam int EB = 7;
    localparam int DEPTH = 4;
    localparam int CW = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_clk_run = 0, cfg_clk_div8 = 0, cfg_clk_idle_hi = 0, cfg_etu_long = 0;
    logic cfg_inverse = 0, cfg_par_chk = 0, cfg_dir_tx = 0;
    logic [CW-1:0] cfg_cwt = '0;
    logic [3:0] irq_mask = '0;
    logic tx_wr = 0, rx_rd = 0, stat_rd = 0, io_in = 1;
    logic [7:0] tx_data = '0;
    logic [7:0] rx_data;
    logic rx_par_ok, irq, card_clk, io_out, io_oe;
    logic [3:0] irq_stat;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sc_char_xcvr #(.CLK_DIV_LO(4), .CLK_DIV_HI(8), .ETU_DIV_A(EA), .ETU_DIV_B(EB),
                   .FIFO_DEPTH(DEPTH), .CWT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_clk_run(cfg_clk_run), .cfg_clk_div8(cfg_clk_div8),
        .cfg_clk_idle_hi(cfg_clk_idle_hi), .cfg_etu_long(cfg_etu_long),
        .cfg_inverse(cfg_inverse), .cfg_par_chk(cfg_par_chk), .cfg_dir_tx(cfg_dir_tx),
        .cfg_cwt(cfg_cwt), .irq_mask(irq_mask), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_par_ok(rx_par_ok), .stat_rd(stat_rd),
        .irq_stat(irq_stat), .irq(irq), .card_clk(card_clk), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int etu_of(logic d8, logic lg);
        return (d8 ? 8 : 4) * (lg ? EB : EA);
    endfunction

    function automatic logic [11:0] line_bits(logic [7:0] d, logic inv, logic badp);
        logic [11:0] f;
        logic p;
        p = ^d ^ badp;
        f = 12'hFFF;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) f[1+i] = inv ? ~d[7-i] : d[i];
        f[9] = inv ? ~p : p;
        return f;
    endfunction

    task automatic clk_period(output int per, output int hi);
        logic prv, r;
        prv = card_clk;
        do begin @(posedge clk); #1; r = !prv && card_clk; prv = card_clk; end while (!r);
        per = 0; hi = 0;
        do begin
            hi += int'(card_clk);
            @(posedge clk); #1;
            per++;
            r = !prv && card_clk; prv = card_clk;
        end while (!r);
    endtask

    task automatic send_char(logic [7:0] d, logic inv, logic badp);
        logic [11:0] f;
        int e;
        f = line_bits(d, inv, badp);
        e = etu_of(cfg_clk_div8, cfg_etu_long);
        @(posedge clk); #1;
        for (int k = 0; k < 12; k++) begin
            io_in = f[k];
            cyc(e);
        end
        io_in = 1'b1;
    endtask

    task automatic read_char(output logic [7:0] d, output logic p);
        d = rx_data; p = rx_par_ok;
        rx_rd = 1'b1; cyc(1); rx_rd = 1'b0;
    endtask

    task automatic pulse_stat_rd();
        stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    endtask

    task automatic tx_one(logic [7:0] d, logic d8, logic lg, logic inv);
        logic [11:0] got;
        int e;
        cfg_clk_div8 = d8; cfg_etu_long = lg; cfg_inverse = inv;
        e = etu_of(d8, lg);
        tx_data = d; tx_wr = 1'b1; cyc(1); tx_wr = 1'b0;
        while (io_out) cyc(1);
        chk("R7 tx request cleared by write", irq_stat[1], 1'b0);
        for (int k = 0; k < 12; k++) begin
            cyc(k == 0 ? e / 2 : e);
            got[k] = io_out;
        end
        chk($sformatf("R3 R4 frame d=%0h div8=%0d long=%0d inv=%0d", d, d8, lg, inv),
            got, line_bits(d, inv, 1'b0));
        cyc(e / 2 + 2);
        chk("R7 tx request after frame", irq_stat[1], 1'b1);
        chk("R3 line idle high", io_out, 1'b1);
    endtask

    task automatic rx_one(logic [7:0] d, logic inv, logic badp, logic pchk, logic exp_ok);
        logic [7:0] gd;
        logic gp;
        cfg_inverse = inv; cfg_par_chk = pchk;
        send_char(d, inv, badp);
        chk("R8 rx ready after character", irq_stat[0], 1'b1);
        read_char(gd, gp);
        chk($sformatf("R5 rx data inv=%0d", inv), gd, d);
        chk("R5 parity flag", gp, exp_ok);
        chk("R8 empty after read", irq_stat[0], 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int per, hi, e;
        logic [7:0] gd;
        logic gp;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // reset state
        chk("R8 R11 reset status", irq_stat, 4'h0);
        chk("R12 reset irq", irq, 1'b0);
        chk("R3 reset line", io_out, 1'b1);
        chk("R2 reset clock parked low", card_clk, 1'b0);
        chk("R6 reset direction", io_oe, 1'b0);

        // R1 card clock divisors
        cfg_clk_run = 1'b1;
        for (int dv = 0; dv < 2; dv++) begin
            cfg_clk_div8 = dv[0];
            cyc(3);
            clk_period(per, hi);
            chk($sformatf("R1 period div8=%0d", dv), per, dv ? 8 : 4);
            chk($sformatf("R1 high time div8=%0d", dv), hi, dv ? 4 : 2);
        end
        // R2 parked level
        for (int lv = 0; lv < 2; lv++) begin
            cfg_clk_run = 1'b0; cfg_clk_idle_hi = lv[0];
            cyc(3);
            chk($sformatf("R2 parked level %0d", lv), card_clk, lv[0]);
        end
        cfg_clk_run = 1'b1;

        // R3 R4 R7 transmit sweep over all timing and convention choices
        cfg_dir_tx = 1'b1; cyc(1);
        chk("R6 driver enabled in transmit", io_oe, 1'b1);
        for (int c = 0; c < 8; c++) begin
            tx_one(8'hA5 ^ 8'(c * 17), c[0], c[1], c[2]);
            tx_one(8'h01 << c, c[0], c[1], c[2]);
        end

        // R6 receive path ignored while transmitting
        cfg_clk_div8 = 0; cfg_etu_long = 0; cfg_inverse = 0;
        send_char(8'h5A, 1'b0, 1'b0);
        cfg_dir_tx = 1'b0; cyc(2);
        chk("R7 tx request cleared by direction change", irq_stat[1], 1'b0);
        chk("R6 driver off in receive", io_oe, 1'b0);
        chk("R6 nothing stored while transmitting", irq_stat[0], 1'b0);

        // R5 R8 receive sweep
        for (int c = 0; c < 8; c++) begin
            cfg_clk_div8 = c[0]; cfg_etu_long = c[1];
            rx_one(8'h3C + 8'(c * 29), c[2], 1'b0, 1'b1, 1'b1);
        end
        cfg_clk_div8 = 0; cfg_etu_long = 0;
        rx_one(8'h96, 1'b0, 1'b1, 1'b1, 1'b0);
        rx_one(8'h96, 1'b1, 1'b1, 1'b1, 1'b0);
        rx_one(8'h71, 1'b0, 1'b1, 1'b0, 1'b1);

        // R9 overflow, R12 masking, R8 order, R11 clear
        cfg_inverse = 0; cfg_par_chk = 1;
        for (int i = 0; i < DEPTH + 1; i++) send_char(8'h10 + 8'(i), 1'b0, 1'b0);
        chk("R9 overflow flag", irq_stat[2], 1'b1);
        irq_mask = 4'hF; cyc(1);
        chk("R12 all masked", irq, 1'b0);
        irq_mask = 4'b1011; cyc(1);
        chk("R12 overflow unmasked", irq, 1'b1);
        for (int i = 0; i < DEPTH; i++) begin
            read_char(gd, gp);
            chk($sformatf("R8 R9 order entry %0d", i), gd, 8'h10 + 8'(i));
        end
        chk("R9 extra byte dropped", irq_stat[0], 1'b0);
        pulse_stat_rd();
        chk("R11 overflow cleared by status read", irq_stat[2], 1'b0);
        chk("R12 irq low after clear", irq, 1'b0);
        irq_mask = 4'h0;

        // R10 wait timer from entry into receive
        e = etu_of(1'b0, 1'b0);
        cfg_dir_tx = 1'b1; cyc(2);
        cfg_cwt = 4'd4; cfg_dir_tx = 1'b0;
        cyc(e * 7 / 2);
        chk("R10 no timeout before 4 ETU", irq_stat[3], 1'b0);
        cyc(e);
        chk("R10 timeout after 4 ETU from entry", irq_stat[3], 1'b1);
        chk("R12 timeout raises irq", irq, 1'b1);
        pulse_stat_rd();
        chk("R11 timeout cleared by status read", irq_stat[3], 1'b0);

        // R10 wait timer from end of character
        send_char(8'hC3, 1'b0, 1'b0);
        chk("R10 no timeout at 12 ETU", irq_stat[3], 1'b0);
        cyc(e);
        chk("R10 no timeout at 13 ETU", irq_stat[3], 1'b0);
        cyc(e);
        chk("R10 timeout at 14 ETU", irq_stat[3], 1'b1);
        read_char(gd, gp);
        chk("R5 data before timeout", gd, 8'hC3);
        pulse_stat_rd();

        // R10 timer off with zero
        cfg_cwt = '0;
        cfg_dir_tx = 1'b1; cyc(2); cfg_dir_tx = 1'b0;
        cyc(e * 10);
        chk("R10 zero wait time disables timer", irq_stat[3], 1'b0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule